// File: doc/BRIEF.md
# Message Object Interface Transfer Controller

This block is the processor-facing side of a CAN-style controller's message store. Software fills a set of staging registers (acceptance mask, arbitration, message control, two 32-bit data words), picks a direction and a set of fields in a command-mask register, and writes an object number to the command register. The block then moves the selected fields between the staging registers and a 32-entry message-object memory. The memory is held as an internal register array, with one wide word per object.

A transfer is a masked read-modify-write. The object word is fetched, the chosen fields are merged, and the result is written back. Objects that are read can have their interrupt-pending and new-data flags cleared in the same operation. The staging control register then receives the flag values from before the clear. The per-object transmit-request, new-data and interrupt-pending flags are held as three 32-bit summary vectors, and these are driven out as ports. Any register access made while a transfer is in flight is held off with a wait signal until the transfer ends.

Top module: `mif_xfer_ctrl`

## Requirements
- R1: An accepted write to the command register (address 0) starts a transfer at once. `busy` is 1 for exactly 3 clock cycles, starting the cycle after the write.
- R2: Any access presented while `busy` is 1 sees `cpu_wait` high and is not performed until `busy` falls. A command write held off in this way runs afterwards and is never lost.
- R3: The object number is command bits 7:0 and reads back from the same bits, with `busy` at bit 15. A value whose low five bits are zero becomes 32. Any other value becomes its low five bits. The field resets to 1.
- R4: Command-mask bit 7 selects the direction, where 1 copies staging into the object. In both directions bit 6 selects Mask, bit 5 Arb, bit 4 Control, bit 3 CIP, bit 2 TxRqst/NewDat, bit 1 data A and bit 0 data B. In write direction only the selected fields of the object change.
- R5: A write with bit 2 set sets the object's transmit request, and the staging TxRqst bit is ignored. With bit 2 clear and Control selected, the staging TxRqst value is stored.
- R6: In read direction (bit 7 = 0) the selected fields are copied into staging, and unselected staging registers keep their values.
- R7: A read with bit 3 set clears the object's interrupt-pending flag. A read with bit 2 set clears its new-data flag. In both cases staging control receives the flag value from before the clear.
- R8: In write direction bit 3 has no effect on any flag.
- R9: The register map uses these addresses: 1 = command mask, 2 = mask, 3 = arbitration, 4 = control, 5 = data A, 6 = data B.
  - Mask layout: bit 31 MXtd, bit 30 MDir, bit 29 reads 1, bits 28:0 ID mask.
  - Arbitration layout: bit 31 MsgVal, bit 30 Xtd, bit 29 Dir, bits 28:0 ID.
  - Control layout: bit 15 NewDat, 14 MsgLst, 13 IntPnd, 12 UMask, 11 TxIE, 10 RxIE, 9 RmtEn, 8 TxRqst, 7 EoB, bits 3:0 DLC. Other bits read 0.
  - After reset, mask reads all ones and all other registers read zero.
- R10: Bit k-1 of each summary vector belongs to object k. The vectors change on the last cycle of the transfer, together with the memory write-back, and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Register access request, held until not waited |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid in the accepted cycle |
| cpu_wait | output | 1 | Access held off while a transfer runs |
| busy | output | 1 | Transfer in progress |
| txrqst_vec | output | NUM_OBJ | Transmit-request flag per object |
| newdat_vec | output | NUM_OBJ | New-data flag per object |
| intpnd_vec | output | NUM_OBJ | Interrupt-pending flag per object |

## Verification
The bench aims at three failure modes:
- Flag clears on read: a design that latched the flag after clearing it would return 0 in staging control where the old flag was 1.
- Forced transmit request on write: a design that let the staging TxRqst bit override the command-mask bit would leave the request vector unchanged.
- Number aliasing and the stalled command: a design that wrapped 0 to 0 instead of 32, or dropped a command written during a transfer, would show up in the number read-back and in the request vector bits of the two objects.

Selective transfers with single fields chosen in each direction catch any merge that touches unselected fields.

// File: rtl/mif_pkg.sv
`timescale 1ns/1ps
package mif_pkg;
   localparam int IDW = 29;
   localparam int DW  = 32;

   // command-mask bit positions (software depends on this order)
   localparam int CM_DIR = 7;
   localparam int CM_MSK = 6;
   localparam int CM_ARB = 5;
   localparam int CM_CTL = 4;
   localparam int CM_CIP = 3;
   localparam int CM_TND = 2;
   localparam int CM_DA  = 1;
   localparam int CM_DB  = 0;

   localparam logic [2:0] A_CREQ = 3'd0;
   localparam logic [2:0] A_CMSK = 3'd1;
   localparam logic [2:0] A_MASK = 3'd2;
   localparam logic [2:0] A_ARB  = 3'd3;
   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_DATA = 3'd5;
   localparam logic [2:0] A_DATB = 3'd6;

   typedef struct packed {
      logic           mxtd;
      logic           mdir;
      logic [IDW-1:0] idm;
   } msk_t;

   typedef struct packed {
      logic           msgval;
      logic           xtd;
      logic           dir;
      logic [IDW-1:0] id;
   } arb_t;

   typedef struct packed {
      logic       msglst;
      logic       umask;
      logic       txie;
      logic       rxie;
      logic       rmten;
      logic       eob;
      logic [3:0] dlc;
   } cfg_t;

   typedef struct packed {
      logic newdat;
      logic intpnd;
      logic txrqst;
   } flg_t;

   typedef struct packed {
      msk_t          msk;
      arb_t          arb;
      cfg_t          cfg;
      logic [DW-1:0] da;
      logic [DW-1:0] db;
   } obj_t;

   typedef enum logic [1:0] {X_IDLE, X_FETCH, X_MERGE, X_STORE} xst_t;
endpackage

// File: rtl/mif_num_alias.sv
`timescale 1ns/1ps
module mif_num_alias #(
   parameter int NUM_OBJ = 32,
   parameter int NUM_W   = 8
) (
   input  logic [NUM_W-1:0]           raw,
   output logic [NUM_W-1:0]           num,
   output logic [$clog2(NUM_OBJ)-1:0] idx
);
   localparam int IW = $clog2(NUM_OBJ);

   if (NUM_W <= IW) begin : g_bad_width
      $error("mif_num_alias: NUM_W must exceed log2(NUM_OBJ)");
   end

   logic [IW-1:0] low;
   assign low = raw[IW-1:0];
   // zero low part means the top object; otherwise keep the low part
   assign num = (low == '0) ? NUM_W'(NUM_OBJ) : NUM_W'(low);
   assign idx = low - IW'(1);
endmodule

// File: rtl/mif_xfer_fsm.sv
`timescale 1ns/1ps
module mif_xfer_fsm
   import mif_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output xst_t st
);
   always_ff @(posedge clk) begin
      if (!rst_n) st <= X_IDLE;
      else begin
         case (st)
            X_IDLE:  if (start) st <= X_FETCH;
            X_FETCH: st <= X_MERGE;
            X_MERGE: st <= X_STORE;
            default: st <= X_IDLE;
         endcase
      end
   end

   // R1: the sequence always runs fetch, merge, store, then idle
   a_r1_fetch_to_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_FETCH) |=> (st == X_MERGE)) else $error("R1 fetch");
   a_r1_merge_to_store: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_MERGE) |=> (st == X_STORE)) else $error("R1 merge");
   a_r1_store_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_STORE) |=> (st == X_IDLE)) else $error("R1 store");
endmodule

// File: rtl/mif_field_merge.sv
`timescale 1ns/1ps
module mif_field_merge
   import mif_pkg::*;
(
   input  logic [7:0]    cm,
   input  msk_t          s_msk,
   input  arb_t          s_arb,
   input  cfg_t          s_cfg,
   input  flg_t          s_flg,
   input  logic [DW-1:0] s_da,
   input  logic [DW-1:0] s_db,
   input  obj_t          o_obj,
   input  flg_t          o_flg,
   output obj_t          n_obj,
   output flg_t          n_flg,
   output msk_t          n_msk,
   output arb_t          n_arb,
   output cfg_t          n_cfg,
   output flg_t          n_sflg,
   output logic [DW-1:0] n_da,
   output logic [DW-1:0] n_db
);
   always_comb begin
      n_obj  = o_obj;
      n_flg  = o_flg;
      n_msk  = s_msk;
      n_arb  = s_arb;
      n_cfg  = s_cfg;
      n_sflg = s_flg;
      n_da   = s_da;
      n_db   = s_db;
      if (cm[CM_DIR]) begin
         if (cm[CM_MSK]) n_obj.msk = s_msk;
         if (cm[CM_ARB]) n_obj.arb = s_arb;
         if (cm[CM_CTL]) begin
            n_obj.cfg = s_cfg;
            n_flg     = s_flg;
         end
         if (cm[CM_TND]) n_flg.txrqst = 1'b1;
         if (cm[CM_DA])  n_obj.da = s_da;
         if (cm[CM_DB])  n_obj.db = s_db;
      end else begin
         if (cm[CM_MSK]) n_msk = o_obj.msk;
         if (cm[CM_ARB]) n_arb = o_obj.arb;
         if (cm[CM_CTL]) begin
            n_cfg  = o_obj.cfg;
            n_sflg = o_flg;
         end
         if (cm[CM_CIP]) begin
            n_sflg.intpnd = o_flg.intpnd;
            n_flg.intpnd  = 1'b0;
         end
         if (cm[CM_TND]) begin
            n_sflg.newdat = o_flg.newdat;
            n_flg.newdat  = 1'b0;
         end
         if (cm[CM_DA]) n_da = o_obj.da;
         if (cm[CM_DB]) n_db = o_obj.db;
      end
   end
endmodule

// File: rtl/mif_xfer_ctrl.sv
`timescale 1ns/1ps
module mif_xfer_ctrl
   import mif_pkg::*;
#(
   parameter int NUM_OBJ = 32,
   parameter int NUM_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [2:0]         cpu_addr,
   input  logic [31:0]        cpu_wdata,
   output logic [31:0]        cpu_rdata,
   output logic               cpu_wait,
   output logic               busy,
   output logic [NUM_OBJ-1:0] txrqst_vec,
   output logic [NUM_OBJ-1:0] newdat_vec,
   output logic [NUM_OBJ-1:0] intpnd_vec
);
   localparam int IW = $clog2(NUM_OBJ);

   if ((NUM_OBJ < 2) || ((NUM_OBJ & (NUM_OBJ - 1)) != 0)) begin : g_bad_depth
      $error("mif_xfer_ctrl: NUM_OBJ must be a power of two");
   end
   if (NUM_W > 15) begin : g_bad_numw
      $error("mif_xfer_ctrl: NUM_W must leave bit 15 for busy");
   end

   xst_t st;
   logic acc, start;
   assign busy     = (st != X_IDLE);
   assign cpu_wait = cpu_req & busy;
   assign acc      = cpu_req & ~busy;
   assign start    = acc & cpu_we & (cpu_addr == A_CREQ);

   mif_xfer_fsm u_fsm (.clk(clk), .rst_n(rst_n), .start(start), .st(st));

   logic [NUM_W-1:0] al_num;
   logic [IW-1:0]    al_idx;
   mif_num_alias #(.NUM_OBJ(NUM_OBJ), .NUM_W(NUM_W)) u_alias (
      .raw(cpu_wdata[NUM_W-1:0]), .num(al_num), .idx(al_idx));

   logic [NUM_W-1:0] num_q;
   logic [IW-1:0]    idx_q;
   logic [7:0]       cm_q;
   msk_t             s_msk;
   arb_t             s_arb;
   cfg_t             s_cfg;
   flg_t             s_flg;
   logic [DW-1:0]    s_da, s_db;

   obj_t          ram [NUM_OBJ];
   obj_t          f_obj, m_obj, mg_obj;
   flg_t          f_flg, m_flg, mg_flg, m_sflg, mg_sflg;
   msk_t          m_msk, mg_msk;
   arb_t          m_arb, mg_arb;
   cfg_t          m_cfg, mg_cfg;
   logic [DW-1:0] m_da, m_db, mg_da, mg_db;

   mif_field_merge u_merge (
      .cm(cm_q), .s_msk(s_msk), .s_arb(s_arb), .s_cfg(s_cfg), .s_flg(s_flg),
      .s_da(s_da), .s_db(s_db), .o_obj(f_obj), .o_flg(f_flg),
      .n_obj(mg_obj), .n_flg(mg_flg), .n_msk(mg_msk), .n_arb(mg_arb),
      .n_cfg(mg_cfg), .n_sflg(mg_sflg), .n_da(mg_da), .n_db(mg_db));

   // staging and command registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         num_q <= NUM_W'(1);
         idx_q <= '0;
         cm_q  <= '0;
         s_msk <= '1;
         s_arb <= '0;
         s_cfg <= '0;
         s_flg <= '0;
         s_da  <= '0;
         s_db  <= '0;
         f_flg <= '0;
      end else begin
         if (acc && cpu_we) begin
            case (cpu_addr)
               A_CREQ: begin num_q <= al_num; idx_q <= al_idx; end
               A_CMSK: cm_q  <= cpu_wdata[7:0];
               A_MASK: s_msk <= {cpu_wdata[31:30], cpu_wdata[IDW-1:0]};
               A_ARB:  s_arb <= cpu_wdata;
               A_CTRL: begin
                  s_flg <= {cpu_wdata[15], cpu_wdata[13], cpu_wdata[8]};
                  s_cfg <= {cpu_wdata[14], cpu_wdata[12], cpu_wdata[11], cpu_wdata[10],
                            cpu_wdata[9], cpu_wdata[7], cpu_wdata[3:0]};
               end
               A_DATA: s_da <= cpu_wdata;
               A_DATB: s_db <= cpu_wdata;
               default: ;
            endcase
         end
         if (st == X_FETCH)
            f_flg <= {newdat_vec[idx_q], intpnd_vec[idx_q], txrqst_vec[idx_q]};
         if ((st == X_STORE) && !cm_q[CM_DIR]) begin
            s_msk <= m_msk;
            s_arb <= m_arb;
            s_cfg <= m_cfg;
            s_flg <= m_sflg;
            s_da  <= m_da;
            s_db  <= m_db;
         end
      end
   end

   // object memory and pipeline stages (contents undefined until written)
   always_ff @(posedge clk) begin
      if (st == X_FETCH) f_obj <= ram[idx_q];
      if (st == X_MERGE) begin
         m_obj  <= mg_obj;
         m_flg  <= mg_flg;
         m_msk  <= mg_msk;
         m_arb  <= mg_arb;
         m_cfg  <= mg_cfg;
         m_sflg <= mg_sflg;
         m_da   <= mg_da;
         m_db   <= mg_db;
      end
      if (st == X_STORE) ram[idx_q] <= m_obj;
   end

   // summary vectors: one flag triple per object
   for (genvar i = 0; i < NUM_OBJ; i++) begin : g_vec
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            newdat_vec[i] <= 1'b0;
            intpnd_vec[i] <= 1'b0;
            txrqst_vec[i] <= 1'b0;
         end else if ((st == X_STORE) && (idx_q == IW'(i))) begin
            newdat_vec[i] <= m_flg.newdat;
            intpnd_vec[i] <= m_flg.intpnd;
            txrqst_vec[i] <= m_flg.txrqst;
         end
      end
   end

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         A_CREQ: begin cpu_rdata = 32'(num_q); cpu_rdata[15] = busy; end
         A_CMSK: cpu_rdata = {24'b0, cm_q};
         A_MASK: cpu_rdata = {s_msk.mxtd, s_msk.mdir, 1'b1, s_msk.idm};
         A_ARB:  cpu_rdata = s_arb;
         A_CTRL: cpu_rdata = {16'b0, s_flg.newdat, s_cfg.msglst, s_flg.intpnd, s_cfg.umask,
                              s_cfg.txie, s_cfg.rxie, s_cfg.rmten, s_flg.txrqst,
                              s_cfg.eob, 3'b0, s_cfg.dlc};
         A_DATA: cpu_rdata = s_da;
         A_DATB: cpu_rdata = s_db;
         default: cpu_rdata = '0;
      endcase
   end

   a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy) else $error("R1 busy");
   a_r2_staging_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st != X_STORE) |=> ($stable(s_msk) && $stable(s_arb) && $stable(s_cfg)
                                   && $stable(num_q) && $stable(cm_q))) else $error("R2 frozen");
   a_r3_num_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (num_q != '0) && (num_q <= NUM_W'(NUM_OBJ))) else $error("R3 range");
   a_r5_txrqst_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_STORE && cm_q[CM_DIR] && cm_q[CM_TND]) |=> txrqst_vec[idx_q]) else $error("R5");
   a_r7_cip_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_STORE && !cm_q[CM_DIR] && cm_q[CM_CIP]) |=> !intpnd_vec[idx_q]) else $error("R7");
   a_r8_cip_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (st == X_STORE && cm_q[CM_DIR] && !cm_q[CM_CTL]) |=> $stable(intpnd_vec)) else $error("R8");
endmodule

// File: tb/tb_mif_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_mif_xfer_ctrl;
   logic        clk = 1'b0;
   logic        rst_n, cpu_req, cpu_we;
   logic [2:0]  cpu_addr;
   logic [31:0] cpu_wdata, cpu_rdata;
   logic        cpu_wait, busy;
   logic [31:0] txrqst_vec, newdat_vec, intpnd_vec;

   always #2.5 clk = ~clk;

   mif_xfer_ctrl dut (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_wait(cpu_wait), .busy(busy), .txrqst_vec(txrqst_vec),
      .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // model state
   logic [31:0] mm [1:32], ma [1:32], mc [1:32], mda [1:32], mdb [1:32];
   logic [31:0] tv = 0, nv = 0, iv = 0;
   logic [31:0] sm = 32'hFFFF_FFFF, sa = 0, sc = 0, sda = 0, sdb = 0;

   // num[7:0], cmask[7:0], seed[31:0]
   localparam logic [47:0] TBL [12] = '{
      {8'd3,   8'hF3, 32'h1234_5678},
      {8'd3,   8'h7F, 32'hDEAD_0000},
      {8'd5,   8'hC0, 32'h0F0F_A5A5},
      {8'd5,   8'h7B, 32'h5555_AAAA},
      {8'd7,   8'h94, 32'h0000_0000},
      {8'd7,   8'h10, 32'hCAFE_F00D},
      {8'd9,   8'h88, 32'h0000_C3C3},
      {8'd9,   8'h0C, 32'h0101_0101},
      {8'h47,  8'h23, 32'h7777_1111},
      {8'h00,  8'hA1, 32'h8888_2222},
      {8'd32,  8'h63, 32'h3333_4444},
      {8'd2,   8'h92, 32'h9999_0100}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic we, input logic [2:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output int waits);
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; waits = 0;
      #1;
      while (cpu_wait) begin waits++; @(negedge clk); #1; end
      rd = cpu_rdata;
      @(posedge clk);
      #1 cpu_req = 0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      logic [31:0] r; int w;
      acc(1'b1, a, d, r, w);
   endtask

   task automatic rdr(input logic [2:0] a, output logic [31:0] r);
      int w;
      acc(1'b0, a, 32'h0, r, w);
   endtask

   function automatic int objof(input logic [7:0] n);
      return (n[4:0] == 0) ? 32 : int'(n[4:0]);
   endfunction

   task automatic do_xfer(input logic [7:0] num, input logic [7:0] cm, input logic [31:0] seed);
      int o; logic [31:0] r; string t;
      o = objof(num);
      wr(3'd1, {24'h0, cm});
      wr(3'd2, seed);                                  sm  = seed | 32'h2000_0000;
      wr(3'd3, seed ^ 32'hA5A5_0F0F);                  sa  = seed ^ 32'hA5A5_0F0F;
      wr(3'd4, {16'h0, seed[15:0] ^ 16'h3C5A});        sc  = {16'h0, seed[15:0] ^ 16'h3C5A} & 32'hFF8F;
      wr(3'd5, {seed[15:0], seed[31:16]});             sda = {seed[15:0], seed[31:16]};
      wr(3'd6, ~seed);                                 sdb = ~seed;
      wr(3'd0, {24'h0, num});
      if (cm[7]) begin
         if (cm[6]) mm[o] = sm;
         if (cm[5]) ma[o] = sa;
         if (cm[4]) begin
            mc[o] = sc & 32'h5E8F;
            nv[o-1] = sc[15]; iv[o-1] = sc[13]; tv[o-1] = sc[8];
         end
         if (cm[2]) tv[o-1] = 1'b1;
         if (cm[1]) mda[o] = sda;
         if (cm[0]) mdb[o] = sdb;
      end else begin
         if (cm[6]) sm = mm[o];
         if (cm[5]) sa = ma[o];
         if (cm[4]) sc = mc[o] | (32'(nv[o-1]) << 15) | (32'(iv[o-1]) << 13) | (32'(tv[o-1]) << 8);
         if (cm[3]) begin sc[13] = iv[o-1]; iv[o-1] = 1'b0; end
         if (cm[2]) begin sc[15] = nv[o-1]; nv[o-1] = 1'b0; end
         if (cm[1]) sda = mda[o];
         if (cm[0]) sdb = mdb[o];
      end
      t = cm[7] ? "R4 write-merge" : "R6 read-staging";
      rdr(3'd2, r); chk({t, " mask"}, r, sm);
      rdr(3'd3, r); chk({t, " arb"},  r, sa);
      rdr(3'd4, r); chk({t, " ctrl (R5 R7 R8)"}, r, sc);
      rdr(3'd5, r); chk({t, " dataA"}, r, sda);
      rdr(3'd6, r); chk({t, " dataB"}, r, sdb);
      chk("R10 txrqst_vec", txrqst_vec, tv);
      chk("R10 newdat_vec", newdat_vec, nv);
      chk("R10 intpnd_vec", intpnd_vec, iv);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog act=hung exp=complete");
      finish_run();
   end

   initial begin
      logic [31:0] r; int w, cnt;
      cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; rst_n = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;

      // reset state
      chk("R1 busy after reset", 32'(busy), 0);
      rdr(3'd0, r); chk("R3 number resets to 1", r, 32'h1);
      rdr(3'd1, r); chk("R9 cmask reset", r, 0);
      rdr(3'd2, r); chk("R9 mask reset all ones", r, 32'hFFFF_FFFF);
      rdr(3'd3, r); chk("R9 arb reset", r, 0);
      rdr(3'd4, r); chk("R9 ctrl reset", r, 0);
      rdr(3'd5, r); chk("R9 dataA reset", r, 0);
      rdr(3'd6, r); chk("R9 dataB reset", r, 0);
      chk("R10 vectors reset", txrqst_vec | newdat_vec | intpnd_vec, 0);

      // fill every object with known content
      for (int o = 1; o <= 32; o++)
         do_xfer(8'(o), 8'hF3, 32'(o) * 32'h0107_0B0D + 32'h9);

      // table of selective transfers
      for (int k = 0; k < 12; k++)
         do_xfer(TBL[k][47:40], TBL[k][39:32], TBL[k][31:0]);

      // R1: busy width
      wr(3'd1, 32'h0);
      wr(3'd0, 32'd4);
      cnt = 0;
      @(negedge clk);
      while (busy && cnt < 20) begin cnt++; @(negedge clk); end
      chk("R1 busy cycles", 32'(cnt), 3);

      // R2: command written during a transfer is held and then executed
      wr(3'd1, 32'h84);
      wr(3'd0, 32'd10);
      acc(1'b1, 3'd0, 32'd11, r, w);
      chk("R2 wait cycles on stalled command", 32'(w), 3);
      rdr(3'd0, r);
      chk("R2 stalled command executed", 32'(txrqst_vec[10]), 1);
      chk("R2 first command executed", 32'(txrqst_vec[9]), 1);
      tv[9] = 1'b1; tv[10] = 1'b1;

      // R3: number aliasing
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h00); rdr(3'd0, r); chk("R3 alias 0x00", r, 32'd32);
      wr(3'd0, 32'hE0); rdr(3'd0, r); chk("R3 alias 0xE0", r, 32'd32);
      wr(3'd0, 32'h41); rdr(3'd0, r); chk("R3 alias 0x41", r, 32'd1);
      wr(3'd0, 32'h3F); rdr(3'd0, r); chk("R3 alias 0x3F", r, 32'd31);
      wr(3'd0, 32'h20); rdr(3'd0, r); chk("R3 keep 0x20", r, 32'd32);
      wr(3'd0, 32'h21); rdr(3'd0, r); chk("R3 alias 0x21", r, 32'd1);

      // R10: end objects map to end bits
      do_xfer(8'd1, 8'h84, 32'h0);
      chk("R10 object 1 is bit 0", 32'(txrqst_vec[0]), 1);
      do_xfer(8'h00, 8'h90, 32'h0);
      chk("R10 object 32 is bit 31 (R5 staging TxRqst)", 32'(txrqst_vec[31]), 0);
      chk("R10 object 32 intpnd bit 31", 32'(intpnd_vec[31]), 1);
      do_xfer(8'd32, 8'h08, 32'h0);
      chk("R7 cip clears bit 31", 32'(intpnd_vec[31]), 0);

      finish_run();
   end
endmodule